// File: doc/BRIEF.md
# Saturating Single-Precision to Integer Converter

This execution slice takes a 32-bit single-precision floating-point word and turns it into a 32-bit integer. Four conversion kinds are available: signed truncation, unsigned truncation, signed floor and signed round-half-up. Every kind saturates. A value the destination cannot hold is forced to the nearest limit of the integer range, and a NaN source gives zero instead of an indefinite pattern.

An operation is issued by raising the valid strobe with the source word, an opcode and a generation select. The opcode is accepted either in its short form or in one of two long forms, which differ from the short form by a fixed offset. The generation select picks which of the two offsets applies. The result and its valid flag come out of registers one clock after issue, so a new conversion can start on every cycle. Subnormal sources are treated as their exact, very small values.

Top module: `fp_to_int_sat`

## Requirements
- R1: Opcode 8 converts to a signed integer, rounding toward zero and clamping to the range -2147483648 to 2147483647.
- R2: Opcode 7 converts to an unsigned integer, rounding toward zero. Any source with the sign bit set, -0.0 included, gives 0, and values of 2^32 or more give 4294967295.
- R3: Opcode 13 converts to a signed integer, rounding toward minus infinity. For example, -0.25 gives -1.
- R4: Opcode 12 converts to a signed integer by computing floor(x + 0.5) exactly. For example, 2.5 gives 3, -2.5 gives -2 and -0.5 gives 0.
- R5: For the signed opcodes, a source beyond the signed range, or an infinity, gives 2147483647 when its sign bit is clear and -2147483648 when it is set.
- R6: A NaN source (exponent field bits [30:23] all ones and fraction bits [22:0] non-zero) gives 0 for every opcode.
- R7: An opcode below 256 is taken as a short-form opcode. Any other opcode is reduced by 384 when the generation select is 0, or by 320 when it is 1, and the remainder is decoded as a short-form opcode. An opcode smaller than the chosen offset matches nothing.
- R8: An opcode that does not decode to one of 7, 8, 12 or 13 gives a result of 0, still flagged valid.
- R9: The output valid flag equals the input valid strobe of the previous cycle. The result register is loaded only on a valid cycle and otherwise holds its value.
- R10: While reset is high, the output valid flag and the result are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the current source and opcode |
| in_opcode | input | 9 | Conversion opcode, short or long form |
| in_gen_sel | input | 1 | Chooses the long-form offset: 0 for 384, 1 for 320 |
| in_src | input | 32 | Single-precision source word |
| out_valid | output | 1 | High one cycle after an issue |
| out_result | output | 32 | Converted integer, two's complement for the signed kinds |

## Verification
The assertions assume that in_opcode, in_gen_sel and in_src are meaningful only in a cycle where in_valid is high. They also assume that reset is held for at least one edge before the first issue, because each property compares the issue cycle with the following one. The stimulus drives these inputs only together with the strobe and holds reset over the first edges. The stimulus sweeps every exponent value, both signs and a set of fraction patterns chosen to sit on, just below and just above the half point. Each point is run under all three opcode forms in rotation, so every stimulus stays inside the valid-qualified contract the properties rely on.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;

  typedef enum logic [2:0] {
    CV_NONE     = 3'd0,
    CV_TRUNC_S  = 3'd1,
    CV_TRUNC_U  = 3'd2,
    CV_FLOOR_S  = 3'd3,
    CV_HALFUP_S = 3'd4
  } cv_kind_t;

  // short-form opcode values that select a conversion
  localparam int OPC_TRUNC_U  = 7;
  localparam int OPC_TRUNC_S  = 8;
  localparam int OPC_HALFUP_S = 12;
  localparam int OPC_FLOOR_S  = 13;

endpackage

// File: rtl/f2i_opdec.sv
`timescale 1ns/1ps
module f2i_opdec
  import f2i_pkg::*;
#(
  parameter int OPW       = 9,
  parameter int SHORT_LIM = 256,
  parameter int BASE_G0   = 384,
  parameter int BASE_G1   = 320
) (
  input  logic [OPW-1:0] opcode,
  input  logic           gen_sel,
  output cv_kind_t       kind
);

  localparam logic [OPW-1:0] LIM_V = OPW'(SHORT_LIM);
  localparam logic [OPW-1:0] B0_V  = OPW'(BASE_G0);
  localparam logic [OPW-1:0] B1_V  = OPW'(BASE_G1);
  localparam logic [OPW-1:0] C_TU  = OPW'(OPC_TRUNC_U);
  localparam logic [OPW-1:0] C_TS  = OPW'(OPC_TRUNC_S);
  localparam logic [OPW-1:0] C_HU  = OPW'(OPC_HALFUP_S);
  localparam logic [OPW-1:0] C_FL  = OPW'(OPC_FLOOR_S);

  logic [OPW-1:0] base;
  logic [OPW-1:0] code;
  logic           in_range;

  // fold the long forms back onto the short opcode space
  always_comb begin
    base = gen_sel ? B1_V : B0_V;
    if (opcode < LIM_V) begin
      code     = opcode;
      in_range = 1'b1;
    end else begin
      code     = opcode - base;
      in_range = (opcode >= base);
    end
  end

  always_comb begin
    kind = CV_NONE;
    if (in_range) begin
      case (code)
        C_TU:    kind = CV_TRUNC_U;
        C_TS:    kind = CV_TRUNC_S;
        C_HU:    kind = CV_HALFUP_S;
        C_FL:    kind = CV_FLOOR_S;
        default: kind = CV_NONE;
      endcase
    end
  end

endmodule

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
module f2i_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W+FRAC_W:0] src,
  output logic                  sign_o,
  output logic                  nan_o,
  output logic                  huge_o,
  output logic [INT_W-1:0]      ipart_o,
  output logic                  half_o,
  output logic                  rest_o
);

  localparam int MANT_W = FRAC_W + 1;
  localparam int FXW    = INT_W + MANT_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int UEW    = EXP_W + 2;
  localparam int SHW    = $clog2(INT_W + 1);

  localparam logic signed [UEW-1:0] BIAS_S = UEW'(BIAS);
  localparam logic signed [UEW-1:0] INT_S  = UEW'(INT_W);
  localparam logic signed [UEW-1:0] NEG1_S = '1;

  logic [EXP_W-1:0]        ef;
  logic [FRAC_W-1:0]       ff;
  logic                    special;
  logic                    tiny;
  logic signed [UEW-1:0]   ue;
  logic signed [UEW-1:0]   ue_p1;
  logic [SHW-1:0]          sh;
  logic [FXW-1:0]          fx;
  logic [MANT_W-1:0]       fbits;

  assign sign_o  = src[EXP_W+FRAC_W];
  assign ef      = src[EXP_W+FRAC_W-1 -: EXP_W];
  assign ff      = src[FRAC_W-1:0];
  assign special = &ef;
  assign nan_o   = special && (|ff);

  // unbiased exponent and the range classes it implies
  always_comb begin
    ue     = $signed({2'b00, ef}) - BIAS_S;
    ue_p1  = ue - NEG1_S;
    huge_o = special || (ue >= INT_S);
    tiny   = (ue < NEG1_S);
    sh     = SHW'(ue_p1);
  end

  // fixed point with MANT_W fraction bits: value * 2^MANT_W
  always_comb begin
    fx    = {{INT_W{1'b0}}, (ef != '0), ff} << sh;
    fbits = fx[MANT_W-1:0];
  end

  always_comb begin
    if (huge_o) begin
      ipart_o = '0;
      half_o  = 1'b0;
      rest_o  = 1'b0;
    end else if (tiny) begin
      // magnitude below one half: only its non-zeroness matters
      ipart_o = '0;
      half_o  = 1'b0;
      rest_o  = |src[EXP_W+FRAC_W-1:0];
    end else begin
      ipart_o = fx[FXW-1 -: INT_W];
      half_o  = fbits[MANT_W-1];
      rest_o  = |fbits[MANT_W-2:0];
    end
  end

endmodule

// File: rtl/f2i_round_sat.sv
`timescale 1ns/1ps
module f2i_round_sat
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  cv_kind_t         kind,
  input  logic             sign,
  input  logic             is_nan,
  input  logic             huge,
  input  logic [INT_W-1:0] ipart,
  input  logic             half,
  input  logic             rest,
  output logic [INT_W-1:0] result
);

  localparam logic [INT_W:0]   POS_LIM_M = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM_M = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] SMAX      = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN      = {1'b1, {(INT_W-1){1'b0}}};

  logic             bump;
  logic [INT_W:0]   mag;
  logic             pos_ovf;
  logic             neg_ovf;
  logic [INT_W-1:0] s_res;
  logic [INT_W-1:0] u_res;

  // magnitude increment chosen by the rounding kind
  always_comb begin
    case (kind)
      CV_FLOOR_S:  bump = sign & (half | rest);
      CV_HALFUP_S: bump = sign ? (half & rest) : half;
      default:     bump = 1'b0;
    endcase
    mag = {1'b0, ipart} + {{INT_W{1'b0}}, bump};
  end

  always_comb begin
    pos_ovf = huge || (mag > POS_LIM_M);
    neg_ovf = huge || (mag > NEG_LIM_M);
    if (sign) s_res = neg_ovf ? SMIN : -mag[INT_W-1:0];
    else      s_res = pos_ovf ? SMAX : mag[INT_W-1:0];
    if (sign)      u_res = '0;
    else if (huge) u_res = '1;
    else           u_res = ipart;
  end

  always_comb begin
    if (is_nan) begin
      result = '0;
    end else begin
      case (kind)
        CV_TRUNC_S, CV_FLOOR_S, CV_HALFUP_S: result = s_res;
        CV_TRUNC_U:                          result = u_res;
        default:                             result = '0;
      endcase
    end
  end

endmodule

// File: rtl/fp_to_int_sat.sv
`timescale 1ns/1ps
module fp_to_int_sat
  import f2i_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int INT_W     = 32,
  parameter int OPW       = 9,
  parameter int SHORT_LIM = 256,
  parameter int BASE_G0   = 384,
  parameter int BASE_G1   = 320
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [OPW-1:0]        in_opcode,
  input  logic                  in_gen_sel,
  input  logic [EXP_W+FRAC_W:0] in_src,
  output logic                  out_valid,
  output logic [INT_W-1:0]      out_result
);

  localparam int SRC_W = EXP_W + FRAC_W + 1;

  cv_kind_t         kind;
  logic             u_sign;
  logic             u_nan;
  logic             u_huge;
  logic [INT_W-1:0] u_ipart;
  logic             u_half;
  logic             u_rest;
  logic [INT_W-1:0] conv;

  f2i_opdec #(
    .OPW(OPW), .SHORT_LIM(SHORT_LIM), .BASE_G0(BASE_G0), .BASE_G1(BASE_G1)
  ) u_dec (
    .opcode (in_opcode),
    .gen_sel(in_gen_sel),
    .kind   (kind)
  );

  f2i_unpack #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
  ) u_unp (
    .src    (in_src),
    .sign_o (u_sign),
    .nan_o  (u_nan),
    .huge_o (u_huge),
    .ipart_o(u_ipart),
    .half_o (u_half),
    .rest_o (u_rest)
  );

  f2i_round_sat #(
    .INT_W(INT_W)
  ) u_rs (
    .kind  (kind),
    .sign  (u_sign),
    .is_nan(u_nan),
    .huge  (u_huge),
    .ipart (u_ipart),
    .half  (u_half),
    .rest  (u_rest),
    .result(conv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= conv;
    end
  end

  logic src_is_nan;
  logic kind_signed;
  assign src_is_nan  = (&in_src[SRC_W-2 -: EXP_W]) && (|in_src[FRAC_W-1:0]);
  assign kind_signed = (kind == CV_TRUNC_S) || (kind == CV_FLOOR_S) ||
                       (kind == CV_HALFUP_S);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));

  // R6
  nan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_is_nan) |=> (out_result == '0));

  // R8
  unknown_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == CV_NONE) |=> (out_result == '0));

  // R2
  uns_neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == CV_TRUNC_U && in_src[SRC_W-1]) |=> (out_result == '0));

  // R5
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_signed && !src_is_nan && !in_src[SRC_W-1])
      |=> !out_result[INT_W-1]);

endmodule

// File: tb/tb_fp_to_int_sat.sv
`timescale 1ns/1ps
module tb_fp_to_int_sat;

  localparam real CLK_P = 8.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [8:0]  in_opcode = '0;
  logic        in_gen_sel = 1'b0;
  logic [31:0] in_src = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fp_to_int_sat dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_gen_sel(in_gen_sel), .in_src(in_src),
    .out_valid(out_valid), .out_result(out_result)
  );

  // kind: 0 none, 1 signed trunc, 2 unsigned trunc, 3 floor, 4 half-up
  function automatic logic [31:0] model(int kind, logic [31:0] b);
    int  ee;
    int  ff;
    real x;
    real r;
    ee = int'(b[30:23]);
    ff = int'(b[22:0]);
    if (kind == 0) return 32'd0;
    if (ee == 255 && ff != 0) return 32'd0;
    if (ee == 255)    x = 1.0e40;
    else if (ee == 0) x = real'(ff) * (2.0 ** (-149));
    else              x = real'(ff + 8388608) * (2.0 ** (ee - 150));
    if (b[31]) x = -x;
    case (kind)
      3:       r = $floor(x);
      4:       r = $floor(x + 0.5);
      default: r = (x >= 0.0) ? $floor(x) : $ceil(x);
    endcase
    if (kind == 2) begin
      if (b[31] || r <= 0.0) return 32'd0;
      if (r > 4294967295.0) return 32'hFFFF_FFFF;
      return 32'(longint'(r));
    end
    if (r > 2147483647.0) return 32'h7FFF_FFFF;
    if (r < -2147483648.0) return 32'h8000_0000;
    return 32'(longint'(r));
  endfunction

  function automatic int short_code(int kind);
    case (kind)
      1: return 8;
      2: return 7;
      3: return 13;
      4: return 12;
      default: return 5;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic xact(int kind, int opc, bit gen, logic [31:0] src, string tag);
    in_opcode  = 9'(opc);
    in_gen_sel = gen;
    in_src     = src;
    in_valid   = 1'b1;
    @(negedge clk);
    check({tag, " valid R9"}, {31'd0, out_valid}, 32'd1);
    check($sformatf("%s op=%0d gen=%0d src=%h", tag, opc, gen, src),
          out_result, model(kind, src));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [22:0] fpat [8];

  initial begin
    fpat[0] = 23'h000000; fpat[1] = 23'h000001; fpat[2] = 23'h400000;
    fpat[3] = 23'h400001; fpat[4] = 23'h3FFFFF; fpat[5] = 23'h7FFFFF;
    fpat[6] = 23'h200000; fpat[7] = 23'h555555;

    repeat (3) @(negedge clk);
    check("R10 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R10 result in reset", out_result, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // named corner points
    xact(4, 12, 0, 32'h4020_0000, "R4 2.5");
    xact(4, 12, 0, 32'hC020_0000, "R4 -2.5");
    xact(4, 12, 0, 32'hBF00_0000, "R4 -0.5");
    xact(4, 12, 0, 32'hBFC0_0000, "R4 -1.5");
    xact(3, 13, 0, 32'hBE80_0000, "R3 -0.25");
    xact(2, 7,  0, 32'h8000_0000, "R2 -0.0");
    xact(2, 7,  0, 32'h4F80_0000, "R2 2^32");
    xact(1, 8,  0, 32'h4F00_0000, "R1 2^31");
    xact(1, 8,  0, 32'hCF00_0000, "R1 -2^31");
    xact(1, 8,  0, 32'hFF80_0000, "R5 -inf");
    xact(3, 13, 0, 32'h7F80_0000, "R5 +inf");
    xact(4, 12, 0, 32'h7FC0_0000, "R6 nan");
    xact(2, 7,  0, 32'hFFC0_0001, "R6 nan");

    // long forms and opcodes that match nothing
    xact(1, 392, 0, 32'h42F6_0000, "R7 long gen0");
    xact(1, 328, 1, 32'hC2F6_0000, "R7 long gen1");
    xact(0, 392, 1, 32'h42F6_0000, "R7 gen1 offset");
    xact(0, 328, 0, 32'h42F6_0000, "R7 below offset");
    xact(0, 5,   0, 32'h42F6_0000, "R8 short unknown");
    xact(0, 255, 0, 32'h42F6_0000, "R8 short unknown");
    xact(0, 384, 0, 32'h42F6_0000, "R8 long unknown");

    // hold behaviour with strobe low
    begin
      logic [31:0] held;
      held = out_result;
      in_valid = 1'b0;
      in_src   = 32'h4480_0000;
      @(negedge clk);
      @(negedge clk);
      check("R9 valid low", {31'd0, out_valid}, 32'd0);
      check("R9 hold", out_result, held);
    end

    // sweep: every exponent, both signs, chosen fractions, all kinds
    for (int e = 0; e < 256; e++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int fi = 0; fi < 8; fi++) begin
          for (int k = 1; k <= 4; k++) begin
            logic [31:0] src;
            string tag;
            int    form;
            int    opc;
            bit    gen;
            src  = {1'(sg), 8'(e), fpat[fi]};
            form = (e + fi + k) % 3;
            opc  = short_code(k) + ((form == 1) ? 384 : (form == 2) ? 320 : 0);
            gen  = (form == 2);
            if (e == 255 && fi != 0)          tag = "R6 sweep";
            else if (k != 2 && e >= 158)      tag = "R5 sweep";
            else if (k == 1)                  tag = "R1 sweep";
            else if (k == 2)                  tag = "R2 sweep";
            else if (k == 3)                  tag = "R3 sweep";
            else                              tag = "R4 sweep";
            if (form != 0) tag = {tag, " R7"};
            xact(k, opc, gen, src, tag);
          end
        end
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule